// File: doc/BRIEF.md
# Compare-Match Timer Channel

One channel of a 16-bit timer, programmed through a small register window with byte-wide and word-wide registers. An up-counter advances on ticks from an internal prescaler. The channel runs only while its own bit is set in a start vector that all channels share. When the counter meets general register A, the channel can restart the count from zero, raise a status flag, request an interrupt and change the level of two output pins. The usual use is a periodic tick: load the period into register A, select clear-on-A, enable the A interrupt and set the run bit.

A two-state controller decides whether the channel counts. `ST_IDLE` is the reset state: the prescaler is held at zero and the counter keeps its value. The transition GO (own run bit seen high at a clock edge) enters `ST_COUNT`, where prescaler ticks advance the counter. The transition HALT (own run bit seen low) returns to `ST_IDLE` and freezes the counter.

Top module: `tmr_channel`

## Requirements
- R1: After reset the counter reads 0, register A reads 0xFFFF, the control, mode, I/O control and enable registers read 0, the status byte reads 0x80, `irq` is 0 and both pins are 0.
- R2: Register offsets: control 0, mode 1, I/O control 2, interrupt enable 4, status 5, counter 6, register A 8. The counter and register A take all 16 data bits; the others use bits 7:0 and read back what was written. The mode byte is stored but has no effect on counting.
- R3: The counter advances only while `start_bits[CH_INDEX]` is 1; with that bit 0 it holds its value, and the other start bits have no effect.
- R4: Control bits 2:0 select the tick rate: 0 every clock, 1 every 4, 2 every 16, 3 every 64; codes 4 to 7 behave as 0.
- R5: Control bits 4:3 select the tick phase: 0 (rising) and 1 (falling) give one tick per prescaler period; 2 and 3 (both) give two, so divide-by-4 ticks every 2 clocks.
- R6: With control bits 7:5 equal to 1, a tick while the counter equals register A loads 0, so the period is (A+1) ticks; every other clear code never clears, and the counter wraps from 0xFFFF to 0.
- R7: A compare match with A sets status bit 0; `irq` is high while any flag is set together with its enable (bit 0 for the A flag, bit 4 for overflow) and stays high until the flag is cleared.
- R8: A status flag is cleared only by reading the status register and then writing 0 to that bit; writing 1, or writing 0 without a preceding read, leaves it set. A flag set in the same cycle as its clearing write stays set.
- R9: A tick that moves the counter from 0xFFFF to 0 by counting sets status bit 4 (overflow).
- R10: The I/O control byte has a pin nibble in bits 7:4 (`out_hi`) and one in bits 3:0 (`out_lo`). Writing codes 1, 2, 3 drives the pin to 0 at once; codes 5, 6, 7 drive it to 1. On each A match, codes 1/5 drive 0, 2/6 drive 1, 3/7 toggle; any other code keeps the pin.
- R11: A software write to the counter loads that value and overrides a count or clear in the same cycle; the match and overflow events of that cycle are dropped.
- R12: Status bit 7 reads 1 (counting up); bits 6, 5 and 3:1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_bits | input | 8 | Shared run vector, one bit per channel |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms status clearing) |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| out_hi | output | 1 | Compare output driven by I/O control bits 7:4 |
| out_lo | output | 1 | Compare output driven by I/O control bits 3:0 |
| irq | output | 1 | Interrupt request |

## Verification
A wrong prescaler or edge state shows as a wrong spacing between toggles of a compare pin, visible within one period of (A+1) ticks, so the bench measures that spacing for every rate and phase. A counter that ignores the run state or the write priority is seen on the next counter read, one clock later. A wrong flag or arming state shows at `irq` and on the status byte at the next access after the acknowledge sequence, and a wrong pin state shows on the pin one clock after the I/O control write or after the next match.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int PRE_W = 6;

    localparam logic [3:0] A_CTRL  = 4'd0;
    localparam logic [3:0] A_MODE  = 4'd1;
    localparam logic [3:0] A_IOCTL = 4'd2;
    localparam logic [3:0] A_IEN   = 4'd4;
    localparam logic [3:0] A_STAT  = 4'd5;
    localparam logic [3:0] A_CNT   = 4'd6;
    localparam logic [3:0] A_GRA   = 4'd8;

    localparam logic [2:0] CLR_ON_A = 3'd1;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_COUNT = 1'b1
    } run_state_t;

    // prescaler terminal value for a rate code
    function automatic logic [PRE_W-1:0] div_last(input logic [2:0] code);
        case (code)
            3'd1:    div_last = PRE_W'(3);
            3'd2:    div_last = PRE_W'(15);
            3'd3:    div_last = PRE_W'(63);
            default: div_last = '0;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] rate_sel,
    input  logic [1:0] phase_sel,
    output logic       tick
);

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] last;
    logic [PRE_W-1:0] mid;
    logic             at_last;
    logic             at_mid;

    assign last    = div_last(rate_sel);
    assign mid     = PRE_W'((32'(last) + 32'd1) / 32'd2 - 32'd1);
    assign at_last = (pre_cnt == last);
    assign at_mid  = (last == '0) || (pre_cnt == mid);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
        end else if (!run || pre_cnt >= last) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    always_comb begin
        tick = 1'b0;
        if (run) begin
            unique case (phase_sel)
                2'd0:    tick = at_last;
                2'd1:    tick = at_mid;
                default: tick = at_last | at_mid;
            endcase
        end
    end

    // R5: single-phase divide-by-4 never ticks two clocks in a row
    a_r5_single_phase_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && phase_sel == 2'd0 && rate_sel == 3'd1 && $stable(rate_sel)) |=> !tick);

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_bit,
    input  logic             tick,
    input  logic [2:0]       clr_sel,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic             running,
    output logic [CNT_W-1:0] cnt,
    output logic             match_a,
    output logic             ovf
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    run_state_t state, state_nx;
    logic       clr_now;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions GO and HALT
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (run_bit)  state_nx = ST_COUNT;
            ST_COUNT: if (!run_bit) state_nx = ST_IDLE;
        endcase
    end

    assign running = (state == ST_COUNT);
    assign match_a = tick && !cnt_wr && (cnt == cmp_a);
    assign clr_now = match_a && (clr_sel == CLR_ON_A);
    assign ovf     = tick && !cnt_wr && !clr_now && (cnt == CNT_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt_wr) begin
            cnt <= cnt_wdata;
        end else if (clr_now) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> cnt == $past(cnt_wdata));

    a_r6_clear_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (match_a && clr_sel == CLR_ON_A) |=> cnt == '0);

    a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !cnt_wr) |=> cnt == $past(cnt));

endmodule

// File: rtl/tmr_status.sv
module tmr_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_a,
    input  logic       set_ovf,
    input  logic       stat_rd,
    input  logic       stat_wr,
    input  logic [7:0] wbyte,
    input  logic [7:0] ien,
    output logic [7:0] stat_byte,
    output logic       irq
);

    logic [1:0] flags;   // [0] compare A, [1] overflow
    logic [1:0] armed;
    logic [1:0] wr_bits;
    logic [1:0] clr;
    logic [1:0] set;

    assign wr_bits = {wbyte[4], wbyte[0]};
    assign set     = {set_ovf, set_a};
    assign clr     = stat_wr ? (armed & ~wr_bits) : 2'b00;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
            armed <= '0;
        end else begin
            flags <= (flags & ~clr) | set;
            if (stat_wr)      armed <= '0;
            else if (stat_rd) armed <= flags;
        end
    end

    assign stat_byte = {1'b1, 2'b00, flags[1], 3'b000, flags[0]};
    assign irq       = (flags[0] & ien[0]) | (flags[1] & ien[4]);

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_a |=> flags[0]);

    a_r8_unarmed_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !armed[0] && flags[0]) |=> flags[0]);

endmodule

// File: rtl/tmr_pin_act.sv
module tmr_pin_act (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] code,
    input  logic       code_wr,
    input  logic [3:0] code_new,
    input  logic       match,
    output logic       pin
);

    logic acts_new;
    logic acts;

    assign acts_new = !code_new[3] && (code_new[1:0] != 2'b00);
    assign acts     = !code[3] && (code[1:0] != 2'b00);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin <= 1'b0;
        end else if (code_wr) begin
            if (acts_new) pin <= code_new[2];
        end else if (match && acts) begin
            unique case (code[1:0])
                2'b01:   pin <= 1'b0;
                2'b10:   pin <= 1'b1;
                default: pin <= ~pin;
            endcase
        end
    end

    a_r10_retain: assert property (@(posedge clk) disable iff (!rst_n)
        (!code_wr && code == 4'd0) |=> $stable(pin));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int START_W  = 8,
    parameter int CH_INDEX = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [START_W-1:0] start_bits,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [3:0]         bus_addr,
    input  logic [CNT_W-1:0]   bus_wdata,
    output logic [CNT_W-1:0]   bus_rdata,
    output logic               out_hi,
    output logic               out_lo,
    output logic               irq
);

    localparam int NPIN = 2;

    logic [7:0]       ctrl, mode, ioctl, ien;
    logic [CNT_W-1:0] cmp_a;
    logic [CNT_W-1:0] cnt;
    logic [7:0]       stat_byte;
    logic             wr_any, rd_stat;
    logic             wr_ctrl, wr_mode, wr_ioctl, wr_ien, wr_stat, wr_cnt, wr_gra;
    logic             running, tick, match_a, ovf;
    logic [NPIN-1:0]  pins;
    logic             unused_start;

    assign unused_start = ^start_bits;

    assign wr_any   = bus_sel && bus_wr;
    assign wr_ctrl  = wr_any && (bus_addr == A_CTRL);
    assign wr_mode  = wr_any && (bus_addr == A_MODE);
    assign wr_ioctl = wr_any && (bus_addr == A_IOCTL);
    assign wr_ien   = wr_any && (bus_addr == A_IEN);
    assign wr_stat  = wr_any && (bus_addr == A_STAT);
    assign wr_cnt   = wr_any && (bus_addr == A_CNT);
    assign wr_gra   = wr_any && (bus_addr == A_GRA);
    assign rd_stat  = bus_sel && bus_rd && (bus_addr == A_STAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl  <= '0;
            mode  <= '0;
            ioctl <= '0;
            ien   <= '0;
            cmp_a <= '1;
        end else begin
            if (wr_ctrl)  ctrl  <= bus_wdata[7:0];
            if (wr_mode)  mode  <= bus_wdata[7:0];
            if (wr_ioctl) ioctl <= bus_wdata[7:0];
            if (wr_ien)   ien   <= bus_wdata[7:0];
            if (wr_gra)   cmp_a <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:  bus_rdata = CNT_W'(ctrl);
            A_MODE:  bus_rdata = CNT_W'(mode);
            A_IOCTL: bus_rdata = CNT_W'(ioctl);
            A_IEN:   bus_rdata = CNT_W'(ien);
            A_STAT:  bus_rdata = CNT_W'(stat_byte);
            A_CNT:   bus_rdata = cnt;
            A_GRA:   bus_rdata = cmp_a;
            default: bus_rdata = '0;
        endcase
    end

    tmr_prescale u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (running),
        .rate_sel  (ctrl[2:0]),
        .phase_sel (ctrl[4:3]),
        .tick      (tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_bit   (start_bits[CH_INDEX]),
        .tick      (tick),
        .clr_sel   (ctrl[7:5]),
        .cmp_a     (cmp_a),
        .cnt_wr    (wr_cnt),
        .cnt_wdata (bus_wdata),
        .running   (running),
        .cnt       (cnt),
        .match_a   (match_a),
        .ovf       (ovf)
    );

    tmr_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_a     (match_a),
        .set_ovf   (ovf),
        .stat_rd   (rd_stat),
        .stat_wr   (wr_stat),
        .wbyte     (bus_wdata[7:0]),
        .ien       (ien),
        .stat_byte (stat_byte),
        .irq       (irq)
    );

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        tmr_pin_act u_pin (
            .clk      (clk),
            .rst_n    (rst_n),
            .code     (ioctl[4*g +: 4]),
            .code_wr  (wr_ioctl),
            .code_new (bus_wdata[4*g +: 4]),
            .match    (match_a),
            .pin      (pins[g])
        );
    end

    assign out_lo = pins[0];
    assign out_hi = pins[1];

    a_r7_irq_on_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (match_a && ien[0] && !wr_ien) |=> irq);

endmodule

// File: tb/tmr_channel_tb.sv
module tmr_channel_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  start_bits = '0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        out_hi, out_lo, irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_channel u_dut (
        .clk(clk), .rst_n(rst_n), .start_bits(start_bits),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .out_hi(out_hi), .out_lo(out_lo), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        bus_sel = 1; bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0; bus_rd = 0;
    endtask

    task automatic ack_all();
        logic [15:0] d;
        rd(4'd5, d);
        wr(4'd5, 16'h0000);
    endtask

    task automatic measure(output int n);
        logic prev;
        int   lim;
        prev = out_lo; lim = 0;
        while (out_lo == prev && lim < 2000) begin @(negedge clk); lim++; end
        prev = out_lo; n = 0;
        while (out_lo == prev && n < 2000) begin @(negedge clk); n++; end
    endtask

    task automatic setup_period(input logic [7:0] c, input logic [15:0] a);
        start_bits = '0;
        wr(4'd0, {8'h00, c});
        wr(4'd8, a);
        wr(4'd6, 16'h0000);
        wr(4'd2, 16'h0003);
        start_bits = 8'h01;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        rd(4'd6, d); check("R1 cnt", d, 0);
        rd(4'd8, d); check("R1 gra", d, 16'hFFFF);
        rd(4'd0, d); check("R1 ctrl", d, 0);
        rd(4'd5, d); check("R1/R12 status", d, 16'h0080);
        check("R1 irq", irq, 0);
        check("R1 pins", {out_hi, out_lo}, 0);
    endtask

    task automatic t_regs();
        logic [15:0] d;
        wr(4'd0, 16'h00AB); rd(4'd0, d); check("R2 ctrl", d, 16'h00AB);
        wr(4'd1, 16'h0070); rd(4'd1, d); check("R2 mode", d, 16'h0070);
        wr(4'd4, 16'h00EE); rd(4'd4, d); check("R2 ien", d, 16'h00EE);
        wr(4'd8, 16'h1234); rd(4'd8, d); check("R2 gra", d, 16'h1234);
        wr(4'd4, 16'h0000);
        wr(4'd0, 16'h0000);
    endtask

    task automatic t_rates();
        int n;
        setup_period(8'h20, 16'd4); measure(n); check("R6 period div1 A=4", n, 5);
        setup_period(8'h21, 16'd3); measure(n); check("R4 div4 A=3", n, 16);
        setup_period(8'h22, 16'd1); measure(n); check("R4 div16 A=1", n, 32);
        setup_period(8'h23, 16'd0); measure(n); check("R4 div64 A=0", n, 64);
        setup_period(8'h24, 16'd2); measure(n); check("R4 code4 as div1", n, 3);
        setup_period(8'h29, 16'd3); measure(n); check("R5 falling div4", n, 16);
        setup_period(8'h31, 16'd3); measure(n); check("R5 both div4", n, 8);
    endtask

    task automatic t_flags();
        logic [15:0] d;
        setup_period(8'h20, 16'd3);
        wr(4'd4, 16'h0000);
        ack_all();
        repeat (10) @(negedge clk);
        start_bits = '0;
        @(negedge clk);
        rd(4'd5, d); check("R7 flag without enable", d & 16'h01, 1);
        check("R7 irq masked", irq, 0);
        wr(4'd4, 16'h0001); check("R7 irq enabled", irq, 1);
        wr(4'd5, 16'h0000);
        rd(4'd5, d); check("R8 clear after read", d & 16'h01, 0);
        check("R8 irq drops", irq, 0);
        start_bits = 8'h01; repeat (10) @(negedge clk); start_bits = '0;
        @(negedge clk);
        wr(4'd5, 16'h0000);
        check("R8 write without read keeps", irq, 1);
        rd(4'd5, d); wr(4'd5, 16'h0001);
        check("R8 write one keeps", irq, 1);
        ack_all();
        wr(4'd4, 16'h0000);
    endtask

    task automatic t_run_gate();
        logic [15:0] a, b;
        start_bits = '0;
        wr(4'd0, 16'h0000);
        wr(4'd6, 16'h0000);
        start_bits = 8'h01; repeat (8) @(negedge clk);
        start_bits = 8'h00; @(negedge clk);
        rd(4'd6, a); repeat (6) @(negedge clk); rd(4'd6, b);
        check("R3 frozen", b, a);
        start_bits = 8'hFE; repeat (6) @(negedge clk);
        rd(4'd6, b); check("R3 other bits ignored", b, a);
        start_bits = 8'h01;
        wr(4'd6, 16'h0100); rd(4'd6, b);
        check("R11 write overrides count", b, 16'h0100);
        start_bits = '0;
    endtask

    task automatic t_no_clear();
        logic [15:0] d;
        start_bits = '0;
        wr(4'd0, 16'h0040);
        wr(4'd8, 16'd5);
        wr(4'd6, 16'h0000);
        start_bits = 8'h01; repeat (30) @(negedge clk); start_bits = '0;
        @(negedge clk);
        rd(4'd6, d); check("R6 code2 no clear", int'(d > 16'd5), 1);
    endtask

    task automatic t_overflow();
        logic [15:0] d;
        start_bits = '0;
        wr(4'd0, 16'h0000);
        wr(4'd8, 16'h0100);
        wr(4'd6, 16'hFFFE);
        ack_all();
        wr(4'd4, 16'h0010);
        check("R9 irq before wrap", irq, 0);
        start_bits = 8'h01; repeat (6) @(negedge clk); start_bits = '0;
        @(negedge clk);
        rd(4'd5, d); check("R9 overflow flag", d, 16'h0090);
        check("R9 irq", irq, 1);
        wr(4'd5, 16'h0000);
        wr(4'd4, 16'h0000);
    endtask

    task automatic t_pins();
        start_bits = '0;
        wr(4'd2, 16'h0051);
        check("R10 init levels", {out_hi, out_lo}, 2'b10);
        wr(4'd2, 16'h0000);
        check("R10 code0 keeps", {out_hi, out_lo}, 2'b10);
        wr(4'd0, 16'h0020);
        wr(4'd8, 16'd2);
        wr(4'd6, 16'd0);
        wr(4'd2, 16'h0052);
        check("R10 init 1/0", {out_hi, out_lo}, 2'b10);
        start_bits = 8'h01; repeat (10) @(negedge clk); start_bits = '0;
        check("R10 clear and set on match", {out_hi, out_lo}, 2'b01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_rates();
        t_flags();
        t_run_gate();
        t_no_clear();
        t_overflow();
        t_pins();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule